// File: doc/BRIEF.md
# Structured Divergence Mask Stack

This block keeps the per-lane activity state that a wide SIMD core needs to run structured control flow. Each resident wave has its own stack of nested conditionals and loops. The core presents one control operation per cycle: a wave index, an opcode, a per-lane predicate vector and an invert bit. The block updates that wave's active-lane mask and its stack.

During the cycle in which an operation is presented, the block reports three things: whether a loop end should branch back to the loop top, whether the construct has just left the wave with no active lanes (the fetch logic may then skip the untaken body), and a sticky error if a push found the stack full. The current active mask of the addressed wave is always visible, so the core can gate register writes and memory side effects with it.

Top module: `dvg_mask_unit`

## Requirements
- R1: After reset every wave has all lanes active and an empty stack. `ovf_err`, `loop_back` and `skip_hint` are low.
- R2: On IF, the effective predicate is `op_pred`, or its bitwise inverse when `op_neg` is 1. The new active mask is the old mask AND the effective predicate.
- R3: On ELSE, the active mask becomes exactly those lanes that were active at the matching IF and had a false effective predicate there.
- R4: On ENDIF, the mask from before the IF is restored, minus any lanes that a break or continue removed inside the construct.
- R5: BREAK removes the active lanes whose effective predicate is 1. They stay inactive until the innermost enclosing loop exits, so with the invert bit set it is the lanes with a 0 predicate that leave.
- R6: CONTINUE parks the active lanes whose effective predicate is 1. They are re-enabled when the enclosing ENDLOOP branches back.
- R7: On ENDLOOP, if any lane is active or parked, `loop_back` is 1 and the mask becomes active OR parked. Otherwise `loop_back` is 0 and the mask returns to the one from before LOOP.
- R8: `skip_hint` is 1 in the cycle of an applied IF, ELSE, BREAK or CONTINUE whose resulting mask is all zero, and 0 otherwise.
- R9: Any mix of IF and LOOP nests up to DEPTH levels (default 32). A push at full depth leaves the mask and stack unchanged and sets `ovf_err`, which stays set until reset.
- R10: An operation changes only the stack and mask of the wave named by `op_wave`.
- R11: These operations have no effect: ELSE or ENDIF when the top entry is not an IF, ENDLOOP when the top entry is not a LOOP, and BREAK or CONTINUE with no enclosing loop.
- R12: The opcode encoding is NOP=0, IF=1, ELSE=2, ENDIF=3, LOOP=4, BREAK=5, CONTINUE=6, ENDLOOP=7.
  - An operation is taken when `op_valid` is 1 at a rising edge.
  - `act_mask` shows the addressed wave's mask from before the operation, and the new mask from the next cycle.
  - `loop_back` and `skip_hint` are valid in the operation's own cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Control operation present |
| op_wave | input | $clog2(WAVES) | Wave addressed by the operation and by `act_mask` |
| op_code | input | 3 | Control opcode (R12) |
| op_pred | input | LANES | Per-lane predicate |
| op_neg | input | 1 | Invert the predicate before use |
| act_mask | output | LANES | Current active mask of the addressed wave |
| loop_back | output | 1 | ENDLOOP requests a branch to the loop top |
| skip_hint | output | 1 | Applied construct left no active lanes |
| ovf_err | output | 1 | Sticky stack overflow |

## Verification
A corrupted saved or parked mask stays hidden while it sits on the stack. It shows on `act_mask` only in the cycle after the ELSE, ENDIF or ENDLOOP that pops or reads that entry, and that can be many operations later. For this reason the sequences close every construct and then read the restored mask directly. A wrong depth count shows up as an ENDIF that is ignored or misapplied, or as a premature `ovf_err`. The full-depth test therefore fills the stack, overflows it, and unwinds it completely.

// File: rtl/dvg_pkg.sv
package dvg_pkg;
  typedef enum logic [2:0] {
    OP_NOP     = 3'd0,
    OP_IF      = 3'd1,
    OP_ELSE    = 3'd2,
    OP_ENDIF   = 3'd3,
    OP_LOOP    = 3'd4,
    OP_BREAK   = 3'd5,
    OP_CONT    = 3'd6,
    OP_ENDLOOP = 3'd7
  } dvg_op_e;
endpackage

// File: rtl/dvg_sticky_flag.sv
module dvg_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk) begin
    if (!rst_n) flag_q <= 1'b0;
    else if (set_i) flag_q <= 1'b1;
  end

  assign flag_o = flag_q;

  // R9: the error never clears on its own
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q |=> flag_q) else $error("overflow flag dropped");

  a_r9_sets: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_q) else $error("overflow flag not set");
endmodule

// File: rtl/dvg_wave_ctx.sv
module dvg_wave_ctx
  import dvg_pkg::*;
#(
  parameter int LANES = 8,
  parameter int DEPTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_i,
  input  dvg_op_e          op_i,
  input  logic [LANES-1:0] pred_i,
  input  logic             neg_i,
  output logic [LANES-1:0] cur_o,
  output logic             loop_back_o,
  output logic             skip_o,
  output logic             ovf_evt_o
);
  localparam int SPW = $clog2(DEPTH + 1);
  localparam int IW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  function automatic logic [LANES-1:0] f_effective(input logic [LANES-1:0] p, input logic n);
    return n ? ~p : p;
  endfunction

  function automatic logic [LANES-1:0] f_loop_next(input logic [LANES-1:0] act,
                                                   input logic [LANES-1:0] parked);
    return act | parked;
  endfunction

  logic [LANES-1:0] saved_q [DEPTH];
  logic [LANES-1:0] pend_q  [DEPTH];
  logic [LANES-1:0] brk_q   [DEPTH];
  logic [DEPTH-1:0] isloop_q;
  logic [SPW-1:0]   sp_q;
  logic [LANES-1:0] cur_q, cur_d;

  logic [LANES-1:0] eff, hit, nxt_loop;
  logic [IW-1:0]    top_idx, sp_idx, lp_idx;
  logic             has_top, top_loop, full, lp_found;
  logic             push_req, push_ok, push_if, else_ev, endif_ev, brk_ev, cont_ev;
  logic             el_ev, loop_back_ev, loop_exit_ev;

  assign eff      = f_effective(pred_i, neg_i);
  assign has_top  = (sp_q != '0);
  assign top_idx  = IW'(sp_q - SPW'(1));
  assign sp_idx   = IW'(sp_q);
  assign top_loop = has_top && isloop_q[top_idx];
  assign full     = (sp_q == SPW'(DEPTH));

  always_comb begin
    lp_found = 1'b0;
    lp_idx   = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (i < int'(sp_q) && isloop_q[i]) begin
        lp_found = 1'b1;
        lp_idx   = IW'(i);
      end
    end
  end

  assign push_req     = sel_i && (op_i == OP_IF || op_i == OP_LOOP);
  assign push_ok      = push_req && !full;
  assign push_if      = push_ok && (op_i == OP_IF);
  assign ovf_evt_o    = push_req && full;
  assign else_ev      = sel_i && (op_i == OP_ELSE) && has_top && !top_loop;
  assign endif_ev     = sel_i && (op_i == OP_ENDIF) && has_top && !top_loop;
  assign brk_ev       = sel_i && (op_i == OP_BREAK) && lp_found;
  assign cont_ev      = sel_i && (op_i == OP_CONT) && lp_found;
  assign el_ev        = sel_i && (op_i == OP_ENDLOOP) && top_loop;
  assign hit          = cur_q & eff;
  assign nxt_loop     = f_loop_next(cur_q, pend_q[top_idx]);
  assign loop_back_ev = el_ev && (nxt_loop != '0);
  assign loop_exit_ev = el_ev && (nxt_loop == '0);

  always_comb begin
    cur_d = cur_q;
    if (push_if)                         cur_d = cur_q & eff;
    else if (else_ev)                    cur_d = pend_q[top_idx];
    else if (endif_ev || loop_exit_ev)   cur_d = saved_q[top_idx];
    else if (brk_ev || cont_ev)          cur_d = cur_q & ~hit;
    else if (loop_back_ev)               cur_d = nxt_loop;
  end

  assign skip_o      = (push_if || else_ev || brk_ev || cont_ev) && (cur_d == '0);
  assign loop_back_o = loop_back_ev;
  assign cur_o       = cur_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q    <= '1;
      sp_q     <= '0;
      isloop_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        saved_q[i] <= '0;
        pend_q[i]  <= '0;
        brk_q[i]   <= '0;
      end
    end else begin
      cur_q <= cur_d;
      if (push_ok) begin
        saved_q[sp_idx]  <= cur_q;
        pend_q[sp_idx]   <= (op_i == OP_IF) ? (cur_q & ~eff) : '0;
        brk_q[sp_idx]    <= '0;
        isloop_q[sp_idx] <= (op_i == OP_LOOP);
        sp_q             <= sp_q + SPW'(1);
      end
      if (else_ev) pend_q[top_idx] <= '0;
      if (endif_ev || loop_exit_ev) sp_q <= sp_q - SPW'(1);
      if (loop_back_ev) pend_q[top_idx] <= '0;
      if (brk_ev || cont_ev) begin
        for (int i = 0; i < DEPTH; i++) begin
          if (i > int'(lp_idx) && i < int'(sp_q)) saved_q[i] <= saved_q[i] & ~hit;
        end
        if (brk_ev) brk_q[lp_idx] <= brk_q[lp_idx] | hit;
        else        pend_q[lp_idx] <= pend_q[lp_idx] | hit;
      end
    end
  end

  // R9: depth never passes the configured limit
  a_r9_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
    sp_q <= SPW'(DEPTH)) else $error("stack depth out of range");

  // R9: a rejected push leaves the wave untouched
  a_r9_ovf_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt_o |=> ($stable(sp_q) && $stable(cur_q))) else $error("overflow changed state");

  // R2: an IF never enables a lane that was inactive
  a_r2_if_narrows: assert property (@(posedge clk) disable iff (!rst_n)
    push_if |=> ((cur_q & ~$past(cur_q)) == '0)) else $error("IF widened mask");

  // R7: a loop exits only once every entering lane has broken out
  a_r7_exit_all_broken: assert property (@(posedge clk) disable iff (!rst_n)
    loop_exit_ev |-> (brk_q[top_idx] == saved_q[top_idx])) else $error("loop exit with live lanes");

  // R7: branching back always leaves some lane running
  a_r7_back_live: assert property (@(posedge clk) disable iff (!rst_n)
    loop_back_ev |=> (cur_q != '0)) else $error("branch back with empty mask");
endmodule

// File: rtl/dvg_mask_unit.sv
module dvg_mask_unit
  import dvg_pkg::*;
#(
  parameter int LANES = 8,
  parameter int WAVES = 4,
  parameter int DEPTH = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     op_valid,
  input  logic [$clog2(WAVES)-1:0] op_wave,
  input  logic [2:0]               op_code,
  input  logic [LANES-1:0]         op_pred,
  input  logic                     op_neg,
  output logic [LANES-1:0]         act_mask,
  output logic                     loop_back,
  output logic                     skip_hint,
  output logic                     ovf_err
);
  localparam int WW = $clog2(WAVES);

  logic [LANES-1:0] cur_all [WAVES];
  logic [WAVES-1:0] lb_all, skip_all, ovf_all;
  dvg_op_e          op;

  assign op = dvg_op_e'(op_code);

  for (genvar w = 0; w < WAVES; w++) begin : g_wave
    dvg_wave_ctx #(.LANES(LANES), .DEPTH(DEPTH)) ctx_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .sel_i      (op_valid && (op_wave == WW'(w))),
      .op_i       (op),
      .pred_i     (op_pred),
      .neg_i      (op_neg),
      .cur_o      (cur_all[w]),
      .loop_back_o(lb_all[w]),
      .skip_o     (skip_all[w]),
      .ovf_evt_o  (ovf_all[w])
    );
  end

  dvg_sticky_flag ovf_i (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (|ovf_all),
    .flag_o(ovf_err)
  );

  assign act_mask  = cur_all[op_wave];
  assign loop_back = |lb_all;
  assign skip_hint = |skip_all;

  // R10: only the addressed wave may report events
  a_r10_one_wave_events: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lb_all | skip_all | ovf_all)) else $error("events from several waves");
endmodule

// File: tb/dvg_mask_unit_tb.sv
module dvg_mask_unit_tb_top;
  localparam int LANES = 8;
  localparam int WAVES = 4;
  localparam int DEPTH = 32;

  localparam logic [2:0] NOP = 3'd0, IF_ = 3'd1, ELS = 3'd2, EIF = 3'd3,
                         LOP = 3'd4, BRK = 3'd5, CNT = 3'd6, ELP = 3'd7;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             op_valid = 1'b0;
  logic [1:0]       op_wave = '0;
  logic [2:0]       op_code = '0;
  logic [LANES-1:0] op_pred = '0;
  logic             op_neg = 1'b0;
  logic [LANES-1:0] act_mask;
  logic             loop_back, skip_hint, ovf_err;

  always #4 clk = ~clk;

  dvg_mask_unit #(.LANES(LANES), .WAVES(WAVES), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_wave(op_wave),
    .op_code(op_code), .op_pred(op_pred), .op_neg(op_neg),
    .act_mask(act_mask), .loop_back(loop_back), .skip_hint(skip_hint), .ovf_err(ovf_err));

  typedef struct {
    logic [LANES-1:0] mask;
    bit               lb;
    bit               sk;
    bit               er;
    string            tag;
  } exp_t;

  exp_t sb_q[$];
  int   checks = 0;
  int   errors = 0;
  bit   exp_err = 1'b0;
  bit   finished = 1'b0;

  // monitor: compares mid-cycle, away from the rising edge
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      checks++;
      if (act_mask !== e.mask || loop_back !== e.lb || skip_hint !== e.sk || ovf_err !== e.er) begin
        errors++;
        $display("FAIL %s: mask/lb/skip/err actual %h/%b/%b/%b expected %h/%b/%b/%b",
                 e.tag, act_mask, loop_back, skip_hint, ovf_err, e.mask, e.lb, e.sk, e.er);
      end
    end
  end

  // driver: one operation per cycle, expectation refers to this cycle
  task automatic step(input logic [1:0] w, input logic [2:0] op, input logic [LANES-1:0] p,
                      input logic n, input logic [LANES-1:0] m, input bit lb, input bit sk,
                      input string tag);
    exp_t e;
    @(posedge clk);
    #2;
    op_valid = 1'b1; op_wave = w; op_code = op; op_pred = p; op_neg = n;
    e.mask = m; e.lb = lb; e.sk = sk; e.er = exp_err; e.tag = tag;
    sb_q.push_back(e);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    step(0, NOP, 8'h00, 0, 8'hFF, 0, 0, "R1 reset mask");
    step(3, NOP, 8'h00, 0, 8'hFF, 0, 0, "R1 reset other wave");
    // conditionals
    step(0, IF_, 8'h0F, 0, 8'hFF, 0, 0, "R2 if issue");
    step(0, NOP, 8'h00, 0, 8'h0F, 0, 0, "R2 if result");
    step(0, ELS, 8'h00, 0, 8'h0F, 0, 0, "R3 else issue");
    step(0, NOP, 8'h00, 0, 8'hF0, 0, 0, "R3 else result");
    step(0, IF_, 8'hF0, 1, 8'hF0, 0, 1, "R8 negated if empties");
    step(0, NOP, 8'h00, 0, 8'h00, 0, 0, "R2 negated if result");
    step(0, EIF, 8'h00, 0, 8'h00, 0, 0, "R4 inner endif");
    step(0, NOP, 8'h00, 0, 8'hF0, 0, 0, "R4 inner restore");
    step(0, EIF, 8'h00, 0, 8'hF0, 0, 0, "R4 outer endif");
    step(0, NOP, 8'h00, 0, 8'hFF, 0, 0, "R4 outer restore");
    // loop with break and continue
    step(0, LOP, 8'h00, 0, 8'hFF, 0, 0, "R7 loop enter");
    step(0, BRK, 8'h03, 0, 8'hFF, 0, 0, "R5 break issue");
    step(0, CNT, 8'h0C, 1, 8'hFC, 0, 0, "R6 negated continue issue");
    step(0, NOP, 8'h00, 0, 8'h0C, 0, 0, "R6 continue parked");
    step(0, IF_, 8'h04, 0, 8'h0C, 0, 0, "R2 if in loop");
    step(0, BRK, 8'hFF, 0, 8'h04, 0, 1, "R8 break empties");
    step(0, ELS, 8'h00, 0, 8'h00, 0, 0, "R3 else in loop");
    step(0, EIF, 8'h00, 0, 8'h08, 0, 0, "R4 endif in loop");
    step(0, ELP, 8'h00, 0, 8'h08, 1, 0, "R12 endloop flags same cycle");
    step(0, NOP, 8'h00, 0, 8'hF8, 0, 0, "R6 continued lanes back");
    step(0, BRK, 8'h00, 1, 8'hF8, 0, 1, "R5 negated break");
    step(0, ELP, 8'h00, 0, 8'h00, 0, 0, "R7 endloop exits");
    step(0, NOP, 8'h00, 0, 8'hFF, 0, 0, "R7 mask after exit");
    // ignored operations
    step(0, EIF, 8'h00, 0, 8'hFF, 0, 0, "R11 endif empty stack");
    step(0, BRK, 8'hFF, 0, 8'hFF, 0, 0, "R11 break outside loop");
    step(0, CNT, 8'hFF, 0, 8'hFF, 0, 0, "R11 continue outside loop");
    step(0, ELP, 8'h00, 0, 8'hFF, 0, 0, "R11 endloop empty stack");
    step(0, LOP, 8'h00, 0, 8'hFF, 0, 0, "R11 loop enter");
    step(0, EIF, 8'h00, 0, 8'hFF, 0, 0, "R11 endif on loop top");
    step(0, ELS, 8'h00, 0, 8'hFF, 0, 0, "R11 else on loop top");
    step(0, NOP, 8'h00, 0, 8'hFF, 0, 0, "R11 mask unchanged");
    step(0, BRK, 8'hFF, 0, 8'hFF, 0, 1, "R5 break all");
    step(0, ELP, 8'h00, 0, 8'h00, 0, 0, "R7 exit after ignored ops");
    step(0, NOP, 8'h00, 0, 8'hFF, 0, 0, "R7 restore");
    // per-wave independence
    step(1, IF_, 8'h01, 0, 8'hFF, 0, 0, "R10 wave1 if");
    step(0, NOP, 8'h00, 0, 8'hFF, 0, 0, "R10 wave0 untouched");
    step(1, NOP, 8'h00, 0, 8'h01, 0, 0, "R10 wave1 narrowed");
    step(2, LOP, 8'h00, 0, 8'hFF, 0, 0, "R10 wave2 loop");
    step(1, EIF, 8'h00, 0, 8'h01, 0, 0, "R10 wave1 endif");
    step(1, NOP, 8'h00, 0, 8'hFF, 0, 0, "R10 wave1 restored");
    step(2, BRK, 8'hFF, 0, 8'hFF, 0, 1, "R10 wave2 break");
    step(2, ELP, 8'h00, 0, 8'h00, 0, 0, "R10 wave2 exit");
    // full depth and overflow on wave 3
    for (int i = 0; i < DEPTH - 1; i++) step(3, IF_, 8'hFF, 0, 8'hFF, 0, 0, "R9 fill");
    step(3, IF_, 8'h55, 0, 8'hFF, 0, 0, "R9 deepest level");
    step(3, IF_, 8'h00, 0, 8'h55, 0, 0, "R9 push at full");
    exp_err = 1'b1;
    step(3, NOP, 8'h00, 0, 8'h55, 0, 0, "R9 overflow flagged, mask kept");
    step(3, EIF, 8'h00, 0, 8'h55, 0, 0, "R9 first pop");
    for (int i = 0; i < DEPTH - 1; i++) step(3, EIF, 8'h00, 0, 8'hFF, 0, 0, "R9 unwind");
    step(3, NOP, 8'h00, 0, 8'hFF, 0, 0, "R9 unwound");
    step(3, EIF, 8'h00, 0, 8'hFF, 0, 0, "R11 endif past bottom");
    step(3, NOP, 8'h00, 0, 8'hFF, 0, 0, "R9 flag still set");
    @(posedge clk);
    #2 op_valid = 1'b0;
    repeat (3) @(posedge clk);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule